// File: doc/BRIEF.md
# ECC Spare-Area Byte Packer

This block takes the check values produced for each 512-byte data chunk of a flash page and stores them into a spare-area byte buffer. The block decides where each byte lands. A chunk result arrives as four 32-bit words. Each word holds two 10-bit check values, one in bits 9:0 and one in bits 25:16; all other bits are don't-care. The block turns the eight values of a chunk into ten bytes with no gaps between the values. It then writes those bytes to spare offsets that depend on the page size and the layout chosen.

Two layouts exist:
- **Table layout.** Offsets follow a fixed placement per page size. Small pages keep the bad-block marker byte and a free region untouched. Larger pages take one contiguous ECC region at the top of the spare area.
- **Infix layout.** Each chunk owns a 16-byte record. The record starts with six pad bytes, followed by the ten ECC bytes.

A start pulse does three things: it fills every spare byte with 0xFF, resets the chunk count, and latches the page size and layout. After the last chunk, software or a DMA engine reads the finished spare image through a byte read port.

Top module: `ecc_spare_packer`

## Requirements
- R1: After reset, and in the cycle after `start_i`, every spare byte reads 0xFF, the chunk count is zero and `overflow_o` is 0.
- R2: For word pair (a, b), where (a, b) is words 0 and 1 for bytes 0..4 and words 2 and 3 for bytes 5..9, the packed bytes are:
  - byte0 = a[7:0]
  - byte1 = {a[21:16], a[9:8]}
  - byte2 = {b[3:0], a[25:22]}
  - byte3 = {b[17:16], b[9:4]}
  - byte4 = b[25:18]
  
  Word bits outside 9:0 and 25:16 have no effect. Word 0 is `chunk_words_i[31:0]`.
- R3: In table layout with `page_sel_i`=0 (512-byte page, one chunk), packed bytes 0..9 go to spare offsets 0,1,2,3,4,6,7,13,14,15. Offsets 5 and 8..12 stay 0xFF.
- R4: In table layout with `page_sel_i`=1 (2048-byte page, four chunks), byte k of chunk c goes to offset 24+10c+k.
- R5: In table layout with `page_sel_i`=2 or 3 (4096-byte page, eight chunks), byte k of chunk c goes to offset 48+10c+k.
- R6: In infix layout (`infix_i`=1), byte k of chunk c goes to offset 16c+6+k. Offsets 16c..16c+5 stay 0xFF.
- R7: A chunk that arrives after the page's chunk count is reached leaves the buffer unchanged and sets `overflow_o`. The flag holds until the next start.
- R8: Page size and layout are sampled only on `start_i`. When `start_i` and `chunk_valid_i` are high in the same cycle, the start wins and the chunk is dropped.
- R9: `rd_data_o` shows the spare byte at `rd_addr_i` combinationally. A chunk written at a clock edge is readable right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a new page: fill the buffer with 0xFF and latch the mode |
| page_sel_i | input | 2 | Page size: 0=512, 1=2048, 2/3=4096 bytes |
| infix_i | input | 1 | 1 selects the infix layout, 0 the table layout |
| chunk_valid_i | input | 1 | One chunk result is present this cycle |
| chunk_words_i | input | 128 | Four result words; word 0 is in bits 31:0 |
| rd_addr_i | input | 7 | Spare byte read address |
| rd_data_o | output | 8 | Spare byte at `rd_addr_i` |
| overflow_o | output | 1 | Sticky flag: a chunk arrived beyond the page's count |

## Verification
Chunk words carry random values in their masked-off bits. A packer that leaks those bits shows up in every byte comparison. Each page size is run with a distinct value pattern per chunk, so a wrong chunk stride or base shows up as a displaced block and not as a coincidence. The small-page table run and the infix run both sweep the whole buffer, which exposes writes into the marker byte, the free region or the pad bytes. Separate sequences cover a start colliding with a chunk and mode inputs changed between starts; these tell start priority and mode latching apart from the layout logic.

// File: rtl/ecc_pack_pkg.sv
package ecc_pack_pkg;

    localparam int WORDS_PER_CHUNK = 4;
    localparam int WORD_W          = 32;
    localparam int VAL_W           = 10;
    localparam int BYTES_PER_PAIR  = 5;
    localparam int ECC_BYTES       = BYTES_PER_PAIR * (WORDS_PER_CHUNK / 2);
    localparam int REC_BYTES       = 16;
    localparam int PAD_BYTES       = REC_BYTES - ECC_BYTES;
    localparam int SPARE_2K        = 64;
    localparam int SPARE_4K        = 128;
    localparam int CHUNKS_2K       = 4;
    localparam int CHUNKS_4K       = 8;
    localparam int BASE_2K         = SPARE_2K - CHUNKS_2K * ECC_BYTES;
    localparam int BASE_4K         = SPARE_4K - CHUNKS_4K * ECC_BYTES;

    localparam logic [WORD_W-1:0] VAL_MASK = 32'h03ff_03ff;

    typedef enum logic [1:0] {
        PG_SMALL = 2'd0,
        PG_MID   = 2'd1,
        PG_LARGE = 2'd2
    } page_e;

    function automatic page_e page_decode(input logic [1:0] sel);
        case (sel)
            2'd0:    return PG_SMALL;
            2'd1:    return PG_MID;
            default: return PG_LARGE;
        endcase
    endfunction

    function automatic int chunks_of(input page_e pg);
        case (pg)
            PG_SMALL: return 1;
            PG_MID:   return CHUNKS_2K;
            default:  return CHUNKS_4K;
        endcase
    endfunction

    // Placement of packed byte k in the single small-page chunk (marker at 5)
    function automatic int small_slot(input int k);
        if (k < 5)      return k;
        else if (k < 7) return k + 1;
        else            return k + 6;
    endfunction

endpackage

// File: rtl/ecc_chunk_packer.sv
module ecc_chunk_packer
    import ecc_pack_pkg::*;
(
    input  logic [WORDS_PER_CHUNK-1:0][WORD_W-1:0] words_i,
    output logic [ECC_BYTES-1:0][7:0]              bytes_o
);

    localparam int PAIRS = WORDS_PER_CHUNK / 2;

    for (genvar j = 0; j < PAIRS; j++) begin : g_pair
        logic [WORD_W-1:0] lo_w;
        logic [WORD_W-1:0] hi_w;

        always_comb begin
            lo_w = words_i[2*j]   & VAL_MASK;
            hi_w = words_i[2*j+1] & VAL_MASK;
            bytes_o[BYTES_PER_PAIR*j + 0] = lo_w[7:0];
            bytes_o[BYTES_PER_PAIR*j + 1] = {lo_w[21:16], lo_w[9:8]};
            bytes_o[BYTES_PER_PAIR*j + 2] = {hi_w[3:0], lo_w[25:22]};
            bytes_o[BYTES_PER_PAIR*j + 3] = {hi_w[17:16], hi_w[9:4]};
            bytes_o[BYTES_PER_PAIR*j + 4] = hi_w[25:18];
        end
    end

endmodule

// File: rtl/ecc_slot_map.sv
module ecc_slot_map
    import ecc_pack_pkg::*;
#(
    parameter int AW = 7,
    parameter int CW = 4
) (
    input  page_e                      page_i,
    input  logic                       infix_i,
    input  logic [CW-1:0]              idx_i,
    output logic [ECC_BYTES-1:0][AW-1:0] slot_o
);

    logic [AW-1:0] idx_w;
    logic [AW-1:0] rec_base;
    logic [AW-1:0] run_base;

    always_comb begin
        idx_w    = AW'(idx_i);
        rec_base = idx_w * AW'(REC_BYTES);
        case (page_i)
            PG_MID:  run_base = AW'(BASE_2K) + idx_w * AW'(ECC_BYTES);
            default: run_base = AW'(BASE_4K) + idx_w * AW'(ECC_BYTES);
        endcase
    end

    for (genvar k = 0; k < ECC_BYTES; k++) begin : g_byte
        localparam int SMALL_OFF = small_slot(k);

        always_comb begin
            if (infix_i)
                slot_o[k] = rec_base + AW'(PAD_BYTES + k);
            else if (page_i == PG_SMALL)
                slot_o[k] = AW'(SMALL_OFF);
            else
                slot_o[k] = run_base + AW'(k);
        end
    end

endmodule

// File: rtl/ecc_spare_packer.sv
module ecc_spare_packer
    import ecc_pack_pkg::*;
#(
    parameter int SPARE_BYTES = 128,
    parameter int MAX_CHUNKS  = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  start_i,
    input  logic [1:0]                            page_sel_i,
    input  logic                                  infix_i,
    input  logic                                  chunk_valid_i,
    input  logic [WORDS_PER_CHUNK*WORD_W-1:0]     chunk_words_i,
    input  logic [$clog2(SPARE_BYTES)-1:0]        rd_addr_i,
    output logic [7:0]                            rd_data_o,
    output logic                                  overflow_o
);

    localparam int AW = $clog2(SPARE_BYTES);
    localparam int CW = $clog2(MAX_CHUNKS + 1);

    typedef struct packed {
        logic [SPARE_BYTES-1:0][7:0] spare;
        logic [CW-1:0]               idx;
        page_e                       page;
        logic                        infix;
        logic                        ovf;
    } state_t;

    state_t st_d, st_q;

    logic [WORDS_PER_CHUNK-1:0][WORD_W-1:0] words;
    logic [ECC_BYTES-1:0][7:0]              packed_bytes;
    logic [ECC_BYTES-1:0][AW-1:0]           slots;
    logic [CW-1:0]                          limit;

    assign words = chunk_words_i;

    ecc_chunk_packer u_pack (
        .words_i (words),
        .bytes_o (packed_bytes)
    );

    ecc_slot_map #(
        .AW (AW),
        .CW (CW)
    ) u_map (
        .page_i  (st_q.page),
        .infix_i (st_q.infix),
        .idx_i   (st_q.idx),
        .slot_o  (slots)
    );

    assign limit = CW'(chunks_of(st_q.page));

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.spare = '1;
            st_d.idx   = '0;
            st_d.ovf   = 1'b0;
            st_d.page  = page_decode(page_sel_i);
            st_d.infix = infix_i;
        end else if (chunk_valid_i) begin
            if (st_q.idx < limit) begin
                for (int k = 0; k < ECC_BYTES; k++) begin
                    st_d.spare[slots[k]] = packed_bytes[k];
                end
                st_d.idx = st_q.idx + CW'(1);
            end else begin
                st_d.ovf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.spare <= '1;
            st_q.idx   <= '0;
            st_q.page  <= PG_SMALL;
            st_q.infix <= 1'b0;
            st_q.ovf   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data_o  = st_q.spare[rd_addr_i];
    assign overflow_o = st_q.ovf;

endmodule

// File: rtl/ecc_spare_packer_chk.sv
module ecc_spare_packer_chk #(
    parameter int SPARE_BYTES = 128
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           start_i,
    input logic [1:0]                     page_sel_i,
    input logic                           infix_i,
    input logic                           chunk_valid_i,
    input logic [$clog2(SPARE_BYTES)-1:0] rd_addr_i,
    input logic [7:0]                     rd_data_o,
    input logic                           overflow_o
);

    logic mode_infix_q;
    logic mode_small_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_infix_q <= 1'b0;
            mode_small_q <= 1'b1;
        end else if (start_i) begin
            mode_infix_q <= infix_i;
            mode_small_q <= (page_sel_i == 2'd0) && !infix_i;
        end
    end

    AST_FILL_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (rd_data_o == 8'hFF && !overflow_o)); // R1

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow_o && !start_i) |=> overflow_o); // R7

    AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow_o) |-> $past(chunk_valid_i && !start_i)); // R7

    AST_MARKER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_small_q && rd_addr_i == 'd5) |-> rd_data_o == 8'hFF); // R3

    AST_PAD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_infix_q && rd_addr_i[3:0] < 4'd6) |-> rd_data_o == 8'hFF); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !chunk_valid_i) |=>
            ($stable(rd_addr_i) -> $stable(rd_data_o))); // R9

endmodule

bind ecc_spare_packer ecc_spare_packer_chk #(.SPARE_BYTES(SPARE_BYTES)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .page_sel_i    (page_sel_i),
    .infix_i       (infix_i),
    .chunk_valid_i (chunk_valid_i),
    .rd_addr_i     (rd_addr_i),
    .rd_data_o     (rd_data_o),
    .overflow_o    (overflow_o)
);

// File: tb/sim_ecc_spare_packer.sv
`timescale 1ns/1ps
module sim_ecc_spare_packer;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [1:0]   page_sel_i = 2'd0;
    logic         infix_i = 1'b0;
    logic         chunk_valid_i = 1'b0;
    logic [127:0] chunk_words_i = '0;
    logic [6:0]   rd_addr_i = '0;
    logic [7:0]   rd_data_o;
    logic         overflow_o;

    int checks = 0;
    int fails  = 0;

    logic [7:0] exp_mem [128];
    int  exp_idx   = 0;
    int  exp_page  = 0;
    bit  exp_infix = 1'b0;
    bit  exp_ovf   = 1'b0;

    always #10 clk = ~clk;

    ecc_spare_packer u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .page_sel_i    (page_sel_i),
        .infix_i       (infix_i),
        .chunk_valid_i (chunk_valid_i),
        .chunk_words_i (chunk_words_i),
        .rd_addr_i     (rd_addr_i),
        .rd_data_o     (rd_data_o),
        .overflow_o    (overflow_o)
    );

    function automatic int n_chunks(input int pg);
        return (pg == 0) ? 1 : (pg == 1) ? 4 : 8;
    endfunction

    function automatic int where(input int pg, input bit inf, input int c, input int k);
        if (inf) return c * 16 + 6 + k;
        if (pg == 0) begin
            case (k)
                5: return 6;
                6: return 7;
                7: return 13;
                8: return 14;
                9: return 15;
                default: return k;
            endcase
        end
        if (pg == 1) return 24 + c * 10 + k;
        return 48 + c * 10 + k;
    endfunction

    // Eight 10-bit values laid end to end, LSB first
    function automatic logic [79:0] bitstream(input logic [127:0] w);
        logic [79:0] s = '0;
        for (int i = 0; i < 4; i++) begin
            s[20*i +: 10]      = w[32*i +: 10];
            s[20*i + 10 +: 10] = w[32*i + 16 +: 10];
        end
        return s;
    endfunction

    task automatic model_fill(input int pg, input bit inf);
        for (int a = 0; a < 128; a++) exp_mem[a] = 8'hFF;
        exp_idx = 0; exp_ovf = 1'b0;
        exp_page = (pg > 2) ? 2 : pg; exp_infix = inf;
    endtask

    task automatic model_chunk(input logic [127:0] w);
        logic [79:0] s = bitstream(w);
        if (exp_idx < n_chunks(exp_page)) begin
            for (int k = 0; k < 10; k++)
                exp_mem[where(exp_page, exp_infix, exp_idx, k)] = s[8*k +: 8];
            exp_idx++;
        end else begin
            exp_ovf = 1'b1;
        end
    endtask

    task automatic check_buffer(input string tag);
        int bad = 0;
        for (int a = 0; a < 128; a++) begin
            rd_addr_i = 7'(a);
            #1;
            if (rd_data_o !== exp_mem[a]) begin
                if (bad < 4)
                    $display("FAIL %s: byte %0d got %02h expected %02h", tag, a, rd_data_o, exp_mem[a]);
                bad++;
            end
        end
        checks++;
        if (bad != 0) fails++;
    endtask

    task automatic check_ovf(input string tag);
        checks++;
        if (overflow_o !== exp_ovf) begin
            fails++;
            $display("FAIL %s: overflow got %0b expected %0b", tag, overflow_o, exp_ovf);
        end
    endtask

    task automatic do_start(input int pg, input bit inf);
        @(negedge clk);
        start_i = 1'b1; page_sel_i = 2'(pg); infix_i = inf;
        @(negedge clk);
        start_i = 1'b0;
        model_fill(pg, inf);
    endtask

    function automatic logic [127:0] make_words();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic send_chunk(input logic [127:0] w);
        @(negedge clk);
        chunk_valid_i = 1'b1; chunk_words_i = w;
        @(negedge clk);
        chunk_valid_i = 1'b0;
        model_chunk(w);
    endtask

    task automatic t_reset();
        model_fill(0, 1'b0);
        check_buffer("R1 reset fill");
        check_ovf("R1 reset overflow");
    endtask

    task automatic t_small_table();
        do_start(0, 1'b0);
        send_chunk(make_words());
        check_buffer("R3 R2 R9 small table layout");
        send_chunk(make_words());
        check_buffer("R7 extra chunk ignored");
        check_ovf("R7 overflow set");
        @(negedge clk);
        check_ovf("R7 overflow sticky");
    endtask

    task automatic t_mid_table();
        do_start(1, 1'b0);
        check_ovf("R1 start clears overflow");
        for (int c = 0; c < 4; c++) begin
            send_chunk(make_words());
            check_buffer("R4 R9 mid table chunk");
        end
        check_ovf("R7 no overflow at exact count");
        send_chunk(make_words());
        check_buffer("R7 mid extra ignored");
        check_ovf("R7 mid overflow");
    endtask

    task automatic t_large_table(input int sel);
        do_start(sel, 1'b0);
        for (int c = 0; c < 8; c++) send_chunk(make_words());
        check_buffer("R5 large table layout");
        check_ovf("R5 no overflow");
    endtask

    task automatic t_infix(input int sel);
        do_start(sel, 1'b1);
        for (int c = 0; c < n_chunks(exp_page); c++) send_chunk(make_words());
        check_buffer("R6 infix layout");
        send_chunk(make_words());
        check_buffer("R6 R7 infix extra ignored");
        check_ovf("R7 infix overflow");
    endtask

    task automatic t_masking();
        logic [127:0] a = make_words();
        logic [127:0] b = a ^ {4{32'hFC00_FC00}};
        logic [7:0]   snap [128];
        do_start(0, 1'b0);
        send_chunk(a);
        for (int i = 0; i < 128; i++) snap[i] = exp_mem[i];
        do_start(0, 1'b0);
        send_chunk(b);
        for (int i = 0; i < 128; i++) exp_mem[i] = snap[i];
        check_buffer("R2 unused word bits ignored");
    endtask

    task automatic t_start_priority();
        do_start(2, 1'b0);
        send_chunk(make_words());
        @(negedge clk);
        start_i = 1'b1; chunk_valid_i = 1'b1; chunk_words_i = make_words();
        page_sel_i = 2'd1; infix_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0; chunk_valid_i = 1'b0;
        model_fill(1, 1'b0);
        check_buffer("R8 start wins over chunk");
        page_sel_i = 2'd0; infix_i = 1'b1;
        send_chunk(make_words());
        check_buffer("R8 mode held until start");
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog: run did not complete");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_small_table();
        t_mid_table();
        t_large_table(2);
        t_large_table(3);
        t_infix(0);
        t_infix(1);
        t_infix(2);
        t_masking();
        t_start_priority();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule